// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block is the interrupt front end of a small processor core. It takes five request lines: a non-maskable request of top priority, three maskable vectored requests (called here the edge, mid and low requests), and a general request that has no vector of its own. One global enable gates all maskable requests. The edge, mid and low requests also have one mask bit each. A byte-wide control write sets those masks and drives a one-bit serial output. A byte-wide status word reports the masks, the enable, the pending requests and a one-bit serial input.

The core raises an instruction-boundary strobe whenever it could branch to a handler. On that cycle the block samples the qualified requests and picks the highest-priority one. On the next cycle it gives a one-cycle take pulse, together with the 16-bit handler address, or with an acknowledge when the general request wins. Accepting any request clears the global enable. Software must set it again. Stack handling and the handler code belong to the core.

Top module: `pic_vec_ctrl`

## Requirements
- R1: When several qualified requests are present at a boundary, the winner follows this order: non-maskable, edge, mid, low, general.
- R2: The handler addresses are 0x0024 (non-maskable), 0x003C (edge), 0x0034 (mid) and 0x002C (low). A general-request win drives `take_ack_o` high and the address 0x0000.
- R3: `take_o` is high for exactly the cycle after a boundary strobe that found a qualified request, and at no other time.
- R4: A rising edge on the edge request sets a pending latch. The latch stays set after the input falls and until it is cleared. A level that stays high after a clear does not set the latch again.
- R5: Control-write bits 2:0 mask low, mid and edge in that order (1 = masked). They are loaded only when bit 3 of the same write is 1. A masked request is never taken.
- R6: Writing control bit 4 as 1 clears the edge latch. Accepting the edge request also clears it.
- R7: When control-write bit 6 is 1, `ser_out_o` takes the value of bit 7. When bit 6 is 0, `ser_out_o` does not change.
- R8: The status byte holds the masks in bits 2:0 and the global enable in bit 3. Bits 4, 5 and 6 hold pending low, mid and edge, whatever the masks are. Bit 7 holds `ser_in_i`.
- R9: `ien_set_i` sets the global enable and `ien_clr_i` clears it. The clear wins when both are high. The general request is gated by the global enable only and never by the masks.
- R10: Accepting any request clears the global enable on the same clock edge that raises `take_o`.
- R11: The non-maskable request ignores the masks and the enable. It is taken only after a rising edge, and only if the input is still high at the boundary. A level held high after it has been taken is not taken again.
- R12: After reset all three masks are 1, the enable and the edge latch are 0, `ser_out_o` is 0 and `take_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Non-maskable request |
| edge_irq_i | input | 1 | Edge-latched maskable request |
| mid_irq_i | input | 1 | Level maskable request, middle priority |
| low_irq_i | input | 1 | Level maskable request, lowest vectored priority |
| gen_irq_i | input | 1 | General non-vectored request |
| ien_set_i | input | 1 | Set global enable |
| ien_clr_i | input | 1 | Clear global enable |
| ctl_wr_i | input | 1 | Control byte write strobe |
| ctl_wdata_i | input | 8 | Control byte |
| status_o | output | 8 | Status byte |
| ser_in_i | input | 1 | Serial input bit |
| ser_out_o | output | 1 | Serial output bit |
| boundary_i | input | 1 | Instruction-boundary strobe |
| take_o | output | 1 | One-cycle accept pulse |
| take_vec_o | output | 16 | Handler address of the accepted request |
| take_ack_o | output | 1 | Acknowledge for an accepted general request |

## Verification
The case hardest to reach is a non-maskable request that rose and then fell before the boundary, placed next to one whose level is still held after it was taken. Both must produce nothing, and both depend on the history of the input rather than its present value. Directed sequences build each history one cycle at a time and then strobe the boundary. A long random phase then lets boundary strobes, enable commands, control writes and short request pulses overlap freely, and a behavioural model checks every output on every clock.

// File: rtl/pic_pkg.sv
package pic_pkg;
   // control byte bit positions
   localparam int CW_MASK_LSB = 0;
   localparam int CW_MASK_UPD = 3;
   localparam int CW_EDGE_CLR = 4;
   localparam int CW_SER_EN   = 6;
   localparam int CW_SER_BIT  = 7;
   // status byte bit positions
   localparam int ST_MASK_LSB = 0;
   localparam int ST_IEN      = 3;
   localparam int ST_PEND_LSB = 4;
   localparam int ST_SER_IN   = 7;
   // request slots, index 0 has top priority
   localparam int NUM_SRC     = 5;
   localparam int SLOT_NMI    = 0;
   localparam int SLOT_EDGE   = 1;
   localparam int SLOT_MID    = 2;
   localparam int SLOT_LOW    = 3;
   localparam int SLOT_GEN    = 4;
   localparam int NUM_MASK    = 3;
endpackage

// File: rtl/pic_edge_unit.sv
module pic_edge_unit #(
   parameter bit LEVEL_HOLD = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic clr_i,
   output logic pend_o
);
   logic prev_q;
   logic pend_q;
   logic rise;

   assign rise = req_i & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= req_i;
   end

   generate
      if (LEVEL_HOLD) begin : g_edge_level
         // armed by an edge, dropped as soon as the level goes away
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend_q <= 1'b0;
            else        pend_q <= req_i & (rise | (pend_q & ~clr_i));
         end
         assign pend_o = pend_q & req_i;

         p_needs_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !req_i |=> !pend_q);
      end else begin : g_edge_latch
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend_q <= 1'b0;
            else        pend_q <= rise | (pend_q & ~clr_i);
         end
         assign pend_o = pend_q;

         p_latch_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q && !clr_i) |=> pend_q);
         p_latch_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !rise) |=> !pend_q);
      end
   endgenerate
endmodule

// File: rtl/pic_ctrl_regs.sv
module pic_ctrl_regs
   import pic_pkg::*;
#(
   parameter int MASKS = NUM_MASK
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [7:0]       wdata_i,
   input  logic             ien_set_i,
   input  logic             ien_clr_i,
   input  logic             take_any_i,
   output logic [MASKS-1:0] mask_o,
   output logic             ien_o,
   output logic             ser_out_o,
   output logic             edge_clr_o
);
   logic unused_wbits;
   assign unused_wbits = wdata_i[5];

   if (MASKS + CW_MASK_LSB > CW_MASK_UPD) begin : g_bad_masks
      $error("mask field overlaps the update bit");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask_o <= '1;
      else if (wr_i && wdata_i[CW_MASK_UPD])
         mask_o <= wdata_i[CW_MASK_LSB +: MASKS];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      ien_o <= 1'b0;
      else if (take_any_i || ien_clr_i) ien_o <= 1'b0;
      else if (ien_set_i)              ien_o <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ser_out_o <= 1'b0;
      else if (wr_i && wdata_i[CW_SER_EN])
         ser_out_o <= wdata_i[CW_SER_BIT];
   end

   assign edge_clr_o = wr_i & wdata_i[CW_EDGE_CLR];

   p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !wdata_i[CW_MASK_UPD]) |=> $stable(mask_o));
   p_ien_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      take_any_i |=> !ien_o);
   p_ser_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_i && wdata_i[CW_SER_EN]) |=> $stable(ser_out_o));
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
   parameter int                     SRCS       = 5,
   parameter int                     VEC_W      = 16,
   parameter int                     NONVEC_IDX = 4,
   parameter logic [SRCS*VEC_W-1:0]  VEC_TABLE  = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             boundary_i,
   input  logic [SRCS-1:0]  req_i,
   output logic [SRCS-1:0]  grant_o,
   output logic             take_o,
   output logic [VEC_W-1:0] vec_o,
   output logic             ack_o
);
   logic             found;
   logic [VEC_W-1:0] sel_vec;

   if (NONVEC_IDX >= SRCS) begin : g_bad_idx
      $error("non-vectored slot out of range");
   end

   always_comb begin
      grant_o = '0;
      found   = 1'b0;
      for (int i = 0; i < SRCS; i++) begin
         if (boundary_i && req_i[i] && !found) begin
            grant_o[i] = 1'b1;
            found      = 1'b1;
         end
      end
   end

   always_comb begin
      sel_vec = '0;
      for (int i = 0; i < SRCS; i++) begin
         if (grant_o[i] && i != NONVEC_IDX)
            sel_vec = VEC_TABLE[i*VEC_W +: VEC_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_o <= 1'b0;
         vec_o  <= '0;
         ack_o  <= 1'b0;
      end else begin
         take_o <= found;
         vec_o  <= sel_vec;
         ack_o  <= grant_o[NONVEC_IDX];
      end
   end

   p_single_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));
   p_take_after_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> $past(boundary_i));
   p_ack_nonvec_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> (take_o && vec_o == '0));
endmodule

// File: rtl/pic_vec_ctrl.sv
module pic_vec_ctrl
   import pic_pkg::*;
#(
   parameter int          VEC_W    = 16,
   parameter logic [15:0] NMI_VEC  = 16'h0024,
   parameter logic [15:0] EDGE_VEC = 16'h003C,
   parameter logic [15:0] MID_VEC  = 16'h0034,
   parameter logic [15:0] LOW_VEC  = 16'h002C
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             nmi_i,
   input  logic             edge_irq_i,
   input  logic             mid_irq_i,
   input  logic             low_irq_i,
   input  logic             gen_irq_i,
   input  logic             ien_set_i,
   input  logic             ien_clr_i,
   input  logic             ctl_wr_i,
   input  logic [7:0]       ctl_wdata_i,
   output logic [7:0]       status_o,
   input  logic             ser_in_i,
   output logic             ser_out_o,
   input  logic             boundary_i,
   output logic             take_o,
   output logic [VEC_W-1:0] take_vec_o,
   output logic             take_ack_o
);
   localparam logic [NUM_SRC*VEC_W-1:0] VTAB = {
      {VEC_W{1'b0}},
      VEC_W'(LOW_VEC), VEC_W'(MID_VEC), VEC_W'(EDGE_VEC), VEC_W'(NMI_VEC)};

   if (VEC_W < 8 || VEC_W > 16) begin : g_bad_width
      $error("VEC_W must be 8 to 16");
   end

   logic [NUM_MASK-1:0] mask;
   logic                ien;
   logic                edge_clr;
   logic                nmi_pend;
   logic                edge_pend;
   logic [NUM_SRC-1:0]  qual;
   logic [NUM_SRC-1:0]  grant;

   pic_edge_unit #(.LEVEL_HOLD(1'b1)) u_nmi (
      .clk(clk), .rst_n(rst_n), .req_i(nmi_i),
      .clr_i(grant[SLOT_NMI]), .pend_o(nmi_pend));

   pic_edge_unit #(.LEVEL_HOLD(1'b0)) u_edge (
      .clk(clk), .rst_n(rst_n), .req_i(edge_irq_i),
      .clr_i(edge_clr | grant[SLOT_EDGE]), .pend_o(edge_pend));

   pic_ctrl_regs #(.MASKS(NUM_MASK)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_i(ctl_wr_i), .wdata_i(ctl_wdata_i),
      .ien_set_i(ien_set_i), .ien_clr_i(ien_clr_i), .take_any_i(|grant),
      .mask_o(mask), .ien_o(ien), .ser_out_o(ser_out_o), .edge_clr_o(edge_clr));

   // mask bit 0 -> low, 1 -> mid, 2 -> edge
   always_comb begin
      qual            = '0;
      qual[SLOT_NMI]  = nmi_pend;
      qual[SLOT_EDGE] = edge_pend  & ~mask[2] & ien;
      qual[SLOT_MID]  = mid_irq_i  & ~mask[1] & ien;
      qual[SLOT_LOW]  = low_irq_i  & ~mask[0] & ien;
      qual[SLOT_GEN]  = gen_irq_i  & ien;
   end

   pic_arbiter #(.SRCS(NUM_SRC), .VEC_W(VEC_W), .NONVEC_IDX(SLOT_GEN),
                 .VEC_TABLE(VTAB)) u_arb (
      .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .req_i(qual),
      .grant_o(grant), .take_o(take_o), .vec_o(take_vec_o), .ack_o(take_ack_o));

   always_comb begin
      status_o = '0;
      status_o[ST_MASK_LSB +: NUM_MASK] = mask;
      status_o[ST_IEN]                  = ien;
      status_o[ST_PEND_LSB]             = low_irq_i;
      status_o[ST_PEND_LSB+1]           = mid_irq_i;
      status_o[ST_PEND_LSB+2]           = edge_pend;
      status_o[ST_SER_IN]               = ser_in_i;
   end

   p_take_drops_ien_r10: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> !status_o[ST_IEN]);
   p_masked_gen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary_i && !ien && !nmi_pend) |=> !take_o);
endmodule

// File: tb/tb_pic_vec_ctrl.sv
module tb_pic_vec_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic nmi_i = 0, edge_irq_i = 0, mid_irq_i = 0, low_irq_i = 0, gen_irq_i = 0;
   logic ien_set_i = 0, ien_clr_i = 0, ctl_wr_i = 0, ser_in_i = 0, boundary_i = 0;
   logic [7:0]  ctl_wdata_i = 0;
   logic [7:0]  status_o;
   logic        ser_out_o, take_o, take_ack_o;
   logic [15:0] take_vec_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   pic_vec_ctrl dut (
      .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .edge_irq_i(edge_irq_i),
      .mid_irq_i(mid_irq_i), .low_irq_i(low_irq_i), .gen_irq_i(gen_irq_i),
      .ien_set_i(ien_set_i), .ien_clr_i(ien_clr_i), .ctl_wr_i(ctl_wr_i),
      .ctl_wdata_i(ctl_wdata_i), .status_o(status_o), .ser_in_i(ser_in_i),
      .ser_out_o(ser_out_o), .boundary_i(boundary_i), .take_o(take_o),
      .take_vec_o(take_vec_o), .take_ack_o(take_ack_o));

   // behavioural reference model
   logic [2:0]  m_mask = 3'b111;
   logic        m_ien = 0, m_latch = 0, m_pe = 0, m_arm = 0, m_pn = 0, m_ser = 0;
   logic        m_take = 0, m_ack = 0;
   logic [15:0] m_vec = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mask = 3'b111; m_ien = 0; m_latch = 0; m_pe = 0; m_arm = 0; m_pn = 0;
         m_ser = 0; m_take = 0; m_ack = 0; m_vec = 0;
      end else begin
         int win;
         logic rise_e, rise_n;
         win = -1;
         if (boundary_i) begin
            if (m_arm && nmi_i)                      win = 0;
            else if (m_latch && !m_mask[2] && m_ien) win = 1;
            else if (mid_irq_i && !m_mask[1] && m_ien) win = 2;
            else if (low_irq_i && !m_mask[0] && m_ien) win = 3;
            else if (gen_irq_i && m_ien)              win = 4;
         end
         rise_e = edge_irq_i && !m_pe;
         rise_n = nmi_i && !m_pn;
         m_take = (win >= 0);
         m_ack  = (win == 4);
         case (win)
            0: m_vec = 16'h0024;
            1: m_vec = 16'h003C;
            2: m_vec = 16'h0034;
            3: m_vec = 16'h002C;
            default: m_vec = 16'h0000;
         endcase
         m_latch = rise_e || (m_latch && !(ctl_wr_i && ctl_wdata_i[4]) && win != 1);
         m_arm   = nmi_i && (rise_n || (m_arm && win != 0));
         if (win >= 0 || ien_clr_i) m_ien = 0;
         else if (ien_set_i)        m_ien = 1;
         if (ctl_wr_i && ctl_wdata_i[3]) m_mask = ctl_wdata_i[2:0];
         if (ctl_wr_i && ctl_wdata_i[6]) m_ser = ctl_wdata_i[7];
         m_pe = edge_irq_i;
         m_pn = nmi_i;
      end
   end

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // every-clock comparison against the model
   always begin
      @(negedge clk);
      #3;
      if (!done) begin
         chk({15'd0, take_o}, {15'd0, m_take}, "R3 take");
         chk(take_vec_o, m_vec, "R1 vector");
         chk({15'd0, take_ack_o}, {15'd0, m_ack}, "R2 ack");
         chk({8'd0, status_o},
             {8'd0, ser_in_i, m_latch, mid_irq_i, low_irq_i, m_ien, m_mask}, "R8 status");
         chk({15'd0, ser_out_o}, {15'd0, m_ser}, "R7 serial");
      end
   end

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic wr(input logic [7:0] d);
      ctl_wr_i = 1; ctl_wdata_i = d; step(); ctl_wr_i = 0; ctl_wdata_i = 0;
   endtask

   task automatic ien_on();
      ien_set_i = 1; step(); ien_set_i = 0;
   endtask

   task automatic bnd();
      boundary_i = 1; step(); boundary_i = 0;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      step(); step();
      // R12 reset state
      chk({8'd0, status_o}, 16'h0007, "R12 status after reset");
      chk({15'd0, ser_out_o}, 16'h0, "R12 serial after reset");
      chk({15'd0, take_o}, 16'h0, "R12 take after reset");
      rst_n = 1;
      step();

      // R9 general request with enable, R10 enable drop
      ien_on();
      chk({15'd0, status_o[3]}, 16'h1, "R9 enable set");
      gen_irq_i = 1; bnd();
      chk({15'd0, take_o}, 16'h1, "R9 general taken");
      chk({15'd0, take_ack_o}, 16'h1, "R2 general ack");
      chk({15'd0, status_o[3]}, 16'h0, "R10 enable dropped");
      bnd();
      chk({15'd0, take_o}, 16'h0, "R9 general blocked without enable");
      gen_irq_i = 0;

      // R5 mask writes
      wr(8'h08);
      chk({13'd0, status_o[2:0]}, 16'h0, "R5 masks cleared");
      wr(8'h07);
      chk({13'd0, status_o[2:0]}, 16'h0, "R5 masks kept without update bit");

      // R1 full priority walk
      ien_on();
      nmi_i = 1; edge_irq_i = 1; mid_irq_i = 1; low_irq_i = 1; gen_irq_i = 1;
      step();
      bnd(); chk(take_vec_o, 16'h0024, "R1 nmi first");
      ien_on(); bnd(); chk(take_vec_o, 16'h003C, "R1 edge second");
      chk({15'd0, status_o[6]}, 16'h0, "R6 latch cleared on accept");
      ien_on(); bnd(); chk(take_vec_o, 16'h0034, "R1 mid third");
      mid_irq_i = 0;
      ien_on(); bnd(); chk(take_vec_o, 16'h002C, "R1 low fourth");
      low_irq_i = 0;
      ien_on(); bnd();
      chk({15'd0, take_ack_o}, 16'h1, "R1 general last");
      chk(take_vec_o, 16'h0000, "R2 general no address");
      nmi_i = 0; edge_irq_i = 0; gen_irq_i = 0; step();

      // R11 non-maskable behaviour
      wr(8'h0F);
      nmi_i = 1; step();
      bnd(); chk(take_vec_o, 16'h0024, "R11 nmi ignores masks and enable");
      bnd(); chk({15'd0, take_o}, 16'h0, "R11 held level not retaken");
      nmi_i = 0; step(); nmi_i = 1; step(); nmi_i = 0; step();
      bnd(); chk({15'd0, take_o}, 16'h0, "R11 edge without level");

      // R5 masked mid, R9 general unaffected by masks, R8 pending shown
      ien_on();
      mid_irq_i = 1; bnd();
      chk({15'd0, take_o}, 16'h0, "R5 masked mid not taken");
      chk({15'd0, status_o[5]}, 16'h1, "R8 mid pending while masked");
      gen_irq_i = 1; bnd();
      chk({15'd0, take_ack_o}, 16'h1, "R9 general ignores masks");
      mid_irq_i = 0; gen_irq_i = 0;

      // R4 latch behaviour, R6 software clear
      edge_irq_i = 1; step(); edge_irq_i = 0; step(); step(); step();
      chk({15'd0, status_o[6]}, 16'h1, "R4 latch holds after pulse");
      wr(8'h10);
      chk({15'd0, status_o[6]}, 16'h0, "R6 software clear");
      edge_irq_i = 1; step();
      chk({15'd0, status_o[6]}, 16'h1, "R4 latch set again");
      wr(8'h10); step(); step();
      chk({15'd0, status_o[6]}, 16'h0, "R4 level does not retrigger");
      edge_irq_i = 0; step();

      // R7 serial output
      wr(8'h80); chk({15'd0, ser_out_o}, 16'h0, "R7 ignored without enable bit");
      wr(8'hC0); chk({15'd0, ser_out_o}, 16'h1, "R7 set");
      wr(8'h40); chk({15'd0, ser_out_o}, 16'h0, "R7 cleared");

      // R8 serial input bit
      ser_in_i = 1; step();
      chk({15'd0, status_o[7]}, 16'h1, "R8 serial input");
      ser_in_i = 0;

      // random phase, compared against the model every clock
      for (int k = 0; k < 4000; k++) begin
         nmi_i      = ($urandom_range(0, 9) == 0) ? ~nmi_i : nmi_i;
         edge_irq_i = ($urandom_range(0, 3) == 0) ? ~edge_irq_i : edge_irq_i;
         mid_irq_i  = ($urandom_range(0, 4) == 0) ? ~mid_irq_i : mid_irq_i;
         low_irq_i  = ($urandom_range(0, 4) == 0) ? ~low_irq_i : low_irq_i;
         gen_irq_i  = ($urandom_range(0, 4) == 0) ? ~gen_irq_i : gen_irq_i;
         ien_set_i  = ($urandom_range(0, 2) == 0);
         ien_clr_i  = ($urandom_range(0, 9) == 0);
         boundary_i = ($urandom_range(0, 2) == 0);
         ctl_wr_i   = ($urandom_range(0, 7) == 0);
         ctl_wdata_i = 8'($urandom);
         ser_in_i   = 1'($urandom);
         step();
      end
      ctl_wr_i = 0; boundary_i = 0; ien_set_i = 0; ien_clr_i = 0;
      step(); step();

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule